// File: doc/BRIEF.md
# Vector Register Hazard Scoreboard

This block keeps the hazard state of one SIMD's vector register file. Each physical register carries two status bits. The pending bit is set when an instruction that will write the register is issued. The busy bit is set when that instruction reaches execute, and at the same moment the pending bit is cleared. A scheduler presents the vector operands of a candidate instruction to a combinational ready query. The query fails while any operand it names has either bit set.

Busy bits are cleared by a pool of countdown timers. An arithmetic destination gets a timer automatically at execute, with a length set by its width: the short bypass latency for 4-byte operands and the long one for 8-byte operands. Memory-class destinations (loads, atomics, fences) get no timer at execute. They stay busy until the memory side presents a return naming the registers, one operand width and a delay. An 8-byte operand claims a register pair, idx and idx+1, and the pair wraps from the last register to register 0. Two counters sort every failed query strobe by the kind of its first blocking operand.

Top module: `vreg_scoreboard`

## Requirements
- R1: After reset every busy and pending bit is clear, no timer is active, both stall counters read 0, `timers_full` is 0, and any query is ready.
- R2: An operand whose wide flag is 1 covers register idx and register (idx+1) mod NUM_REGS. Its status is the OR of both entries, and every set or clear hits both entries, so a wide operand at NUM_REGS-1 also covers register 0.
- R3: `chk_ready` is 0 exactly when at least one operand with its `chk_valid` bit at 1 covers a register whose busy or pending bit is set. Operands with `chk_valid` at 0 have no effect.
- R4: In a cycle with `chk_strobe` at 1 and `chk_ready` at 0, exactly one counter increments by 1, selected by the lowest-numbered blocking operand: `waw_stalls` if its `chk_dst` is 1, `raw_stalls` if it is 0. In any other cycle neither counter changes.
- R5: An issue slot with `iss_en` at 1 sets the pending bits it covers. They are visible to the query from the next cycle.
- R6: An execute slot with `exe_en` at 1 sets the busy bits it covers and clears their pending bits, both at the same clock edge.
- R7: When `exe_mem` is 0, each executed destination is released SP_LAT clock edges after its execute edge if narrow, or DP_LAT edges after if wide.
- R8: When `exe_mem` is 1, executed destinations stay busy with no time limit. A return slot with `ret_en` at 1 releases its register (width `ret_wide`) `ret_delay` edges after the return edge. A delay of 0 acts as 1.
- R9: `timers_full` is 1 exactly when all NUM_SLOTS timers are active. A timer frees at the edge where it releases. Requests are served by execute slots first, then return slots, in slot order.
- R10: If a release and an execute set hit the same register at one edge, the register stays busy. If an issue set and an execute clear hit the same register at one edge, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | NUM_OPS | Query operand is a vector register |
| chk_idx | input | NUM_OPS*IDX_W | Query operand register indices, operand k in bits k*IDX_W upward |
| chk_wide | input | NUM_OPS | Query operand is 8 bytes |
| chk_dst | input | NUM_OPS | Query operand is a destination |
| chk_strobe | input | 1 | Query is a real scheduling attempt and counts toward stalls |
| chk_ready | output | 1 | No valid query operand is hazarded (combinational) |
| iss_en | input | NUM_OPS | Issue destination slot enables |
| iss_idx | input | NUM_OPS*IDX_W | Issue destination indices |
| iss_wide | input | NUM_OPS | Issue destination is 8 bytes |
| exe_en | input | NUM_OPS | Execute destination slot enables |
| exe_idx | input | NUM_OPS*IDX_W | Execute destination indices |
| exe_wide | input | NUM_OPS | Execute destination is 8 bytes |
| exe_mem | input | 1 | Executing instruction is a load, atomic or fence |
| ret_en | input | NUM_OPS | Memory return register enables |
| ret_idx | input | NUM_OPS*IDX_W | Memory return register indices |
| ret_wide | input | 1 | Memory return operand width is 8 bytes |
| ret_delay | input | DLY_W | Memory return release delay in cycles |
| timers_full | output | 1 | Every release timer is active |
| waw_stalls | output | CNT_W | Queries blocked first by a destination operand |
| raw_stalls | output | CNT_W | Queries blocked first by a source operand |

## Verification
The bench probes the wraparound pair at the last register. A design that forgot the modulo would leave register 0 free, or would index past the array. It drives a second execute into the exact edge where the first one's timer fires. A design that let the release win would report a busy register as ready. It holds a memory destination for many cycles and then returns it with delay 0, which catches a timer started at execute and a zero delay that never fires. It fills every timer slot to watch `timers_full` rise and fall. Random queries with mixed valid, wide and destination flags check that a disabled operand is ignored, and that the stall counters charge only the lowest blocking operand.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

  typedef enum logic {
    STALL_RAW = 1'b0,
    STALL_WAW = 1'b1
  } stall_kind_e;

  function automatic int unsigned pick_latency(logic wide, int unsigned sp, int unsigned dp);
    return wide ? dp : sp;
  endfunction

endpackage

// File: rtl/vsb_span.sv
// Expands one operand (index, width) into a per-register mask.
module vsb_span #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4
) (
  input  logic                en,
  input  logic [IDX_W-1:0]    idx,
  input  logic                wide,
  output logic [NUM_REGS-1:0] mask
);
  logic [IDX_W-1:0] nxt;

  assign nxt = (idx == IDX_W'(NUM_REGS - 1)) ? '0 : idx + 1'b1;

  always_comb begin
    mask = '0;
    if (en) begin
      mask[idx] = 1'b1;
      if (wide) mask[nxt] = 1'b1;
      assert_pair_span_R2: assert ($countones(mask) == (wide ? 2 : 1));
    end
  end
endmodule

// File: rtl/vsb_status.sv
// Per-register pending and busy bits plus the parallel ready query.
module vsb_status
  import vsb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_OPS  = 4,
  parameter int IDX_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REGS-1:0]      inf_set,
  input  logic [NUM_REGS-1:0]      inf_clr,
  input  logic [NUM_REGS-1:0]      busy_set,
  input  logic [NUM_REGS-1:0]      busy_clr,
  input  logic [NUM_OPS-1:0]       chk_valid,
  input  logic [NUM_OPS*IDX_W-1:0] chk_idx,
  input  logic [NUM_OPS-1:0]       chk_wide,
  input  logic [NUM_OPS-1:0]       chk_dst,
  output logic                     chk_ready,
  output logic                     blk_any,
  output stall_kind_e              blk_kind,
  output logic [NUM_REGS-1:0]      busy_q,
  output logic [NUM_REGS-1:0]      infl_q
);
  logic [NUM_REGS-1:0] hazard;
  logic [NUM_OPS-1:0]  hit;

  assign hazard = busy_q | infl_q;

  genvar o;
  generate
    for (o = 0; o < NUM_OPS; o++) begin : g_op
      logic [IDX_W-1:0] a;
      logic [IDX_W-1:0] b;
      assign a = chk_idx[o*IDX_W +: IDX_W];
      assign b = (a == IDX_W'(NUM_REGS - 1)) ? '0 : a + 1'b1;
      assign hit[o] = chk_valid[o] & (hazard[a] | (chk_wide[o] & hazard[b]));
    end
  endgenerate

  always_comb begin
    blk_any  = 1'b0;
    blk_kind = STALL_RAW;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (hit[k] && !blk_any) begin
        blk_any  = 1'b1;
        blk_kind = chk_dst[k] ? STALL_WAW : STALL_RAW;
      end
    end
  end

  assign chk_ready = ~blk_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      infl_q <= '0;
    end else begin
      busy_q <= (busy_q & ~busy_clr) | busy_set;
      infl_q <= (infl_q & ~inf_clr) | inf_set;
    end
  end

  genvar r;
  generate
    for (r = 0; r < NUM_REGS; r++) begin : g_chk
      assert_busy_set_R6: assert property (@(posedge clk) disable iff (rst)
        busy_set[r] |=> busy_q[r]);
      assert_pending_set_R5: assert property (@(posedge clk) disable iff (rst)
        inf_set[r] |=> infl_q[r]);
      assert_pending_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (inf_clr[r] && !inf_set[r]) |=> !infl_q[r]);
    end
  endgenerate
endmodule

// File: rtl/vsb_timer_pool.sv
// Pool of countdown slots; a slot that reaches its last cycle releases its span.
module vsb_timer_pool #(
  parameter int NUM_REGS  = 16,
  parameter int NUM_SLOTS = 8,
  parameter int NREQ      = 8,
  parameter int IDX_W     = 4,
  parameter int DLY_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREQ-1:0]         req_v,
  input  logic [NREQ*IDX_W-1:0]   req_idx,
  input  logic [NREQ-1:0]         req_wide,
  input  logic [NREQ*DLY_W-1:0]   req_dly,
  output logic [NUM_REGS-1:0]     rel_mask,
  output logic                    full
);
  localparam int SRC_W = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [NUM_SLOTS-1:0] vld;
  logic [NUM_SLOTS-1:0] fire;
  logic [NUM_SLOTS-1:0] claim;
  logic [NUM_SLOTS-1:0] swide;
  logic [IDX_W-1:0]     sidx [NUM_SLOTS];
  logic [DLY_W-1:0]     scnt [NUM_SLOTS];
  logic [SRC_W-1:0]     src  [NUM_SLOTS];
  logic [NUM_REGS-1:0]  smask [NUM_SLOTS];
  logic [NREQ-1:0]      placed;

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign fire[s] = vld[s] && (scnt[s] <= DLY_W'(1));

      vsb_span #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_span (
        .en   (fire[s]),
        .idx  (sidx[s]),
        .wide (swide[s]),
        .mask (smask[s])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          vld[s]   <= 1'b0;
          swide[s] <= 1'b0;
          sidx[s]  <= '0;
          scnt[s]  <= '0;
        end else if (claim[s]) begin
          vld[s]   <= 1'b1;
          sidx[s]  <= req_idx[src[s]*IDX_W +: IDX_W];
          swide[s] <= req_wide[src[s]];
          scnt[s]  <= (req_dly[src[s]*DLY_W +: DLY_W] == '0) ? DLY_W'(1)
                                                            : req_dly[src[s]*DLY_W +: DLY_W];
        end else if (fire[s]) begin
          vld[s] <= 1'b0;
        end else if (vld[s]) begin
          scnt[s] <= scnt[s] - 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    rel_mask = '0;
    for (int k = 0; k < NUM_SLOTS; k++) rel_mask = rel_mask | smask[k];
  end

  // Request q takes the lowest-numbered idle slot not yet taken by a lower request.
  always_comb begin
    claim  = '0;
    placed = '0;
    for (int k = 0; k < NUM_SLOTS; k++) src[k] = '0;
    for (int q = 0; q < NREQ; q++) begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        if (req_v[q] && !placed[q] && !vld[k] && !claim[k]) begin
          claim[k]  = 1'b1;
          src[k]    = SRC_W'(q);
          placed[q] = 1'b1;
        end
      end
    end
  end

  assign full = &vld;

  assert_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (full && !(|fire)) |=> full);
endmodule

// File: rtl/vsb_stall_count.sv
// Classifies each blocked query strobe.
module vsb_stall_count
  import vsb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             blk_any,
  input  stall_kind_e      blk_kind,
  output logic [CNT_W-1:0] waw_cnt,
  output logic [CNT_W-1:0] raw_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      waw_cnt <= '0;
      raw_cnt <= '0;
    end else if (strobe && blk_any) begin
      if (blk_kind == STALL_WAW) waw_cnt <= waw_cnt + 1'b1;
      else                       raw_cnt <= raw_cnt + 1'b1;
    end
  end

  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((CNT_W+1)'(waw_cnt) + (CNT_W+1)'(raw_cnt)
                    - (CNT_W+1)'($past(waw_cnt)) - (CNT_W+1)'($past(raw_cnt))
                    == (CNT_W+1)'($past(strobe && blk_any))));
endmodule

// File: rtl/vreg_scoreboard.sv
module vreg_scoreboard
  import vsb_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int MIN_ALLOC = 4,
  parameter int NUM_OPS   = 4,
  parameter int NUM_SLOTS = 8,
  parameter int SP_LAT    = 3,
  parameter int DP_LAT    = 6,
  parameter int DLY_W     = 8,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_OPS-1:0]       chk_valid,
  input  logic [NUM_OPS*IDX_W-1:0] chk_idx,
  input  logic [NUM_OPS-1:0]       chk_wide,
  input  logic [NUM_OPS-1:0]       chk_dst,
  input  logic                     chk_strobe,
  output logic                     chk_ready,
  input  logic [NUM_OPS-1:0]       iss_en,
  input  logic [NUM_OPS*IDX_W-1:0] iss_idx,
  input  logic [NUM_OPS-1:0]       iss_wide,
  input  logic [NUM_OPS-1:0]       exe_en,
  input  logic [NUM_OPS*IDX_W-1:0] exe_idx,
  input  logic [NUM_OPS-1:0]       exe_wide,
  input  logic                     exe_mem,
  input  logic [NUM_OPS-1:0]       ret_en,
  input  logic [NUM_OPS*IDX_W-1:0] ret_idx,
  input  logic                     ret_wide,
  input  logic [DLY_W-1:0]         ret_delay,
  output logic                     timers_full,
  output logic [CNT_W-1:0]         waw_stalls,
  output logic [CNT_W-1:0]         raw_stalls
);
  localparam int NREQ = 2 * NUM_OPS;

  generate
    if ((NUM_REGS % 2) != 0 || (NUM_REGS % MIN_ALLOC) != 0 || NUM_REGS < 2) begin : g_bad_cfg
      $error("vreg_scoreboard: register count must be even and a multiple of the allocation granule");
    end
  endgenerate

  logic [NUM_REGS-1:0] iss_mask [NUM_OPS];
  logic [NUM_REGS-1:0] exe_mask [NUM_OPS];
  logic [NUM_REGS-1:0] pend_set, exe_hit, rel_mask, busy_q, infl_q;
  logic [NREQ-1:0]       req_v, req_wide;
  logic [NREQ*IDX_W-1:0] req_idx;
  logic [NREQ*DLY_W-1:0] req_dly;
  logic                  blk_any;
  stall_kind_e           blk_kind;

  genvar g;
  generate
    for (g = 0; g < NUM_OPS; g++) begin : g_port
      vsb_span #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_iss (
        .en(iss_en[g]), .idx(iss_idx[g*IDX_W +: IDX_W]), .wide(iss_wide[g]), .mask(iss_mask[g]));
      vsb_span #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_exe (
        .en(exe_en[g]), .idx(exe_idx[g*IDX_W +: IDX_W]), .wide(exe_wide[g]), .mask(exe_mask[g]));

      assign req_v[g]                           = exe_en[g] & ~exe_mem;
      assign req_idx[g*IDX_W +: IDX_W]          = exe_idx[g*IDX_W +: IDX_W];
      assign req_wide[g]                        = exe_wide[g];
      assign req_dly[g*DLY_W +: DLY_W]          = DLY_W'(pick_latency(exe_wide[g], SP_LAT, DP_LAT));
      assign req_v[NUM_OPS+g]                   = ret_en[g];
      assign req_idx[(NUM_OPS+g)*IDX_W +: IDX_W] = ret_idx[g*IDX_W +: IDX_W];
      assign req_wide[NUM_OPS+g]                = ret_wide;
      assign req_dly[(NUM_OPS+g)*DLY_W +: DLY_W] = ret_delay;
    end
  endgenerate

  always_comb begin
    pend_set = '0;
    exe_hit  = '0;
    for (int k = 0; k < NUM_OPS; k++) begin
      pend_set = pend_set | iss_mask[k];
      exe_hit  = exe_hit  | exe_mask[k];
    end
  end

  vsb_timer_pool #(
    .NUM_REGS(NUM_REGS), .NUM_SLOTS(NUM_SLOTS), .NREQ(NREQ), .IDX_W(IDX_W), .DLY_W(DLY_W)
  ) u_pool (
    .clk(clk), .rst(rst), .req_v(req_v), .req_idx(req_idx), .req_wide(req_wide),
    .req_dly(req_dly), .rel_mask(rel_mask), .full(timers_full)
  );

  vsb_status #(.NUM_REGS(NUM_REGS), .NUM_OPS(NUM_OPS), .IDX_W(IDX_W)) u_status (
    .clk(clk), .rst(rst),
    .inf_set(pend_set), .inf_clr(exe_hit), .busy_set(exe_hit), .busy_clr(rel_mask),
    .chk_valid(chk_valid), .chk_idx(chk_idx), .chk_wide(chk_wide), .chk_dst(chk_dst),
    .chk_ready(chk_ready), .blk_any(blk_any), .blk_kind(blk_kind),
    .busy_q(busy_q), .infl_q(infl_q)
  );

  vsb_stall_count #(.CNT_W(CNT_W)) u_stall (
    .clk(clk), .rst(rst), .strobe(chk_strobe), .blk_any(blk_any), .blk_kind(blk_kind),
    .waw_cnt(waw_stalls), .raw_cnt(raw_stalls)
  );

  genvar r;
  generate
    for (r = 0; r < NUM_REGS; r++) begin : g_rel
      assert_release_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rel_mask[r] && !exe_hit[r]) |=> !busy_q[r]);
      assert_set_beats_release_R10: assert property (@(posedge clk) disable iff (rst)
        (rel_mask[r] && exe_hit[r]) |=> busy_q[r]);
    end
  endgenerate

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (busy_q == '0 && infl_q == '0 && !timers_full
                    && waw_stalls == '0 && raw_stalls == '0));
endmodule

// File: tb/sim_vreg_scoreboard.sv
module sim_vreg_scoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 16, NO = 4, NS = 8, SPL = 3, DPL = 6, IW = 4, DW = 8, CW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [NO-1:0]    chk_valid = '0, chk_wide = '0, chk_dst = '0;
  logic [NO*IW-1:0] chk_idx = '0, iss_idx = '0, exe_idx = '0, ret_idx = '0;
  logic             chk_strobe = 1'b0, exe_mem = 1'b0, ret_wide = 1'b0;
  logic [NO-1:0]    iss_en = '0, iss_wide = '0, exe_en = '0, exe_wide = '0, ret_en = '0;
  logic [DW-1:0]    ret_delay = '0;
  logic             chk_ready, timers_full;
  logic [CW-1:0]    waw_stalls, raw_stalls;

  vreg_scoreboard #(.NUM_REGS(NR), .MIN_ALLOC(4), .NUM_OPS(NO), .NUM_SLOTS(NS),
    .SP_LAT(SPL), .DP_LAT(DPL), .DLY_W(DW), .CNT_W(CW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  bit busy_m [NR];
  bit inf_m  [NR];
  bit pv [NS];
  int preg [NS];
  bit pwide [NS];
  int prem [NS];
  int waw_m = 0, raw_m = 0;
  int nchk = 0, nerr = 0;
  bit finished = 0;
  string tag = "R1";

  task automatic check(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int nx(int i); return (i + 1) % NR; endfunction

  function automatic bit op_hit(int o);
    int a = int'(chk_idx[o*IW +: IW]);
    if (!chk_valid[o]) return 0;
    return busy_m[a] | inf_m[a] | (chk_wide[o] & (busy_m[nx(a)] | inf_m[nx(a)]));
  endfunction

  function automatic int pend_cnt();
    int n = 0;
    for (int s = 0; s < NS; s++) n += pv[s];
    return n;
  endfunction

  function automatic void pend_add(int r, bit w, int d);
    for (int s = 0; s < NS; s++)
      if (!pv[s]) begin pv[s] = 1; preg[s] = r; pwide[s] = w; prem[s] = (d < 1) ? 1 : d; return; end
  endfunction

  function automatic void model_step();
    bit clr [NR];
    bit setb [NR];
    bit isb [NR];
    bit rdy = 1;
    int first = -1;
    for (int r = 0; r < NR; r++) begin clr[r] = 0; setb[r] = 0; isb[r] = 0; end
    for (int o = NO - 1; o >= 0; o--) if (op_hit(o)) begin rdy = 0; first = o; end
    if (chk_strobe && !rdy) begin
      if (chk_dst[first]) waw_m++; else raw_m++;
    end
    for (int s = 0; s < NS; s++)
      if (pv[s]) begin
        if (prem[s] <= 1) begin
          clr[preg[s]] = 1; if (pwide[s]) clr[nx(preg[s])] = 1; pv[s] = 0;
        end else prem[s]--;
      end
    for (int o = 0; o < NO; o++) begin
      if (iss_en[o]) begin
        isb[int'(iss_idx[o*IW +: IW])] = 1;
        if (iss_wide[o]) isb[nx(int'(iss_idx[o*IW +: IW]))] = 1;
      end
      if (exe_en[o]) begin
        setb[int'(exe_idx[o*IW +: IW])] = 1;
        if (exe_wide[o]) setb[nx(int'(exe_idx[o*IW +: IW]))] = 1;
        if (!exe_mem) pend_add(int'(exe_idx[o*IW +: IW]), exe_wide[o], exe_wide[o] ? DPL : SPL);
      end
    end
    for (int o = 0; o < NO; o++)
      if (ret_en[o]) pend_add(int'(ret_idx[o*IW +: IW]), ret_wide, int'(ret_delay));
    for (int r = 0; r < NR; r++) begin
      busy_m[r] = (busy_m[r] & !clr[r]) | setb[r];
      inf_m[r]  = (inf_m[r] & !setb[r]) | isb[r];
    end
  endfunction

  function automatic bit model_ready();
    for (int o = 0; o < NO; o++) if (op_hit(o)) return 0;
    return 1;
  endfunction

  // One clock: inputs already driven; compare ready, step model, compare registered outputs.
  task automatic cyc();
    #1;
    check(chk_ready == model_ready(), tag, "chk_ready", chk_ready, model_ready());
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(waw_stalls == CW'(waw_m), "R4", "waw_stalls", waw_stalls, waw_m);
    check(raw_stalls == CW'(raw_m), "R4", "raw_stalls", raw_stalls, raw_m);
    check(timers_full == (pend_cnt() == NS), "R9", "timers_full", timers_full, pend_cnt() == NS);
  endtask

  task automatic idle();
    iss_en = '0; exe_en = '0; ret_en = '0; exe_mem = 0; chk_strobe = 0;
  endtask

  task automatic q1(int o, bit v, int r, bit w, bit d);
    chk_valid[o] = v; chk_idx[o*IW +: IW] = IW'(r); chk_wide[o] = w; chk_dst[o] = d;
  endtask

  task automatic query_only(int r, bit w);
    chk_valid = '0; q1(0, 1, r, w, 0);
  endtask

  task automatic waitn(int n);
    for (int i = 0; i < n; i++) begin idle(); cyc(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_9bdf));
    for (int r = 0; r < NR; r++) begin busy_m[r] = 0; inf_m[r] = 0; end
    for (int s = 0; s < NS; s++) pv[s] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: clean state after reset, all four operands valid
    tag = "R1";
    for (int o = 0; o < NO; o++) q1(o, 1, o * 3, 1, o[0]);
    chk_strobe = 1;
    #1;
    check(chk_ready == 1'b1, "R1", "ready after reset", chk_ready, 1);
    check(waw_stalls == 0 && raw_stalls == 0, "R1", "counters after reset", waw_stalls + raw_stalls, 0);
    check(timers_full == 1'b0, "R1", "full after reset", timers_full, 0);
    cyc();

    // R5: issue narrow reg 5 then query it
    tag = "R5";
    idle(); iss_en[0] = 1; iss_idx[0 +: IW] = 5; iss_wide[0] = 0; query_only(5, 0); cyc();
    idle(); query_only(5, 0); #1;
    check(chk_ready == 1'b0, "R5", "pending reg blocks", chk_ready, 0);
    cyc();

    // R6 then R7: execute reg 5, watch narrow release
    tag = "R6";
    idle(); exe_en[0] = 1; exe_idx[0 +: IW] = 5; exe_wide[0] = 0; query_only(5, 0); cyc();
    tag = "R7"; query_only(5, 0); waitn(SPL + 1);
    #1; check(chk_ready == 1'b1, "R7", "narrow release done", chk_ready, 1);

    // R2: wide pair at the last register wraps to register 0
    tag = "R2";
    idle(); iss_en[1] = 1; iss_idx[IW +: IW] = IW'(NR - 1); iss_wide[1] = 1; cyc();
    query_only(0, 0); #1;
    check(chk_ready == 1'b0, "R2", "register 0 held by wrapped pair", chk_ready, 0);
    cyc();
    tag = "R7";
    idle(); exe_en[2] = 1; exe_idx[2*IW +: IW] = IW'(NR - 1); exe_wide[2] = 1; query_only(0, 0); cyc();
    query_only(0, 0); waitn(DPL + 1);
    #1; check(chk_ready == 1'b1, "R7", "wide release done", chk_ready, 1);

    // R3: a disabled operand naming a busy register is ignored
    tag = "R3";
    idle(); exe_en[0] = 1; exe_mem = 1; exe_idx[0 +: IW] = 7; exe_wide[0] = 0; cyc();
    idle(); chk_valid = '0; q1(1, 0, 7, 0, 1); q1(2, 1, 3, 0, 0); #1;
    check(chk_ready == 1'b1, "R3", "invalid operand ignored", chk_ready, 1);
    cyc();

    // R8: memory destination stays busy, then released by return with delay 0
    tag = "R8";
    query_only(7, 0); waitn(20);
    #1; check(chk_ready == 1'b0, "R8", "memory dest still busy", chk_ready, 0);
    idle(); ret_en[0] = 1; ret_idx[0 +: IW] = 7; ret_wide = 0; ret_delay = 0; query_only(7, 0); cyc();
    idle(); query_only(7, 0); cyc();
    #1; check(chk_ready == 1'b1, "R8", "zero delay return", chk_ready, 1);
    idle(); exe_en[0] = 1; exe_mem = 1; exe_idx[0 +: IW] = 10; exe_wide[0] = 1; cyc();
    idle(); ret_en[3] = 1; ret_idx[3*IW +: IW] = 10; ret_wide = 1; ret_delay = 4; query_only(11, 0); cyc();
    query_only(11, 0); waitn(5);

    // R10: new execute lands on the release edge; issue beats execute clear
    tag = "R10";
    idle(); exe_en[0] = 1; exe_idx[0 +: IW] = 9; exe_wide[0] = 0; query_only(9, 0); cyc();
    query_only(9, 0); waitn(SPL - 1);
    idle(); exe_en[0] = 1; exe_idx[0 +: IW] = 9; query_only(9, 0); cyc();
    idle(); query_only(9, 0); #1;
    check(chk_ready == 1'b0, "R10", "set wins over release", chk_ready, 0);
    waitn(SPL + 1);
    idle(); iss_en[0] = 1; iss_idx[0 +: IW] = 12; exe_en[1] = 1; exe_idx[IW +: IW] = 12; exe_mem = 1; cyc();
    idle(); ret_en[0] = 1; ret_idx[0 +: IW] = 12; ret_wide = 0; ret_delay = 1; cyc();
    idle(); query_only(12, 0); cyc();
    #1; check(chk_ready == 1'b0, "R10", "pending kept over execute clear", chk_ready, 0);
    idle(); exe_en[0] = 1; exe_idx[0 +: IW] = 12; exe_mem = 0; cyc(); waitn(SPL + 1);

    // R9: fill all timers with long returns
    tag = "R9";
    idle(); ret_en = '1; ret_wide = 0; ret_delay = 30; ret_idx = {4'd3, 4'd2, 4'd1, 4'd0}; cyc();
    idle(); ret_en = '1; ret_idx = {4'd7, 4'd6, 4'd5, 4'd4}; cyc();
    idle(); #1;
    check(timers_full == 1'b1, "R9", "all slots active", timers_full, 1);
    waitn(32);

    // R4 and R3: random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int need;
      tag = "R3";
      idle();
      for (int o = 0; o < NO; o++)
        q1(o, $urandom_range(0, 3) != 0, $urandom_range(0, NR - 1), $urandom_range(0, 1), $urandom_range(0, 1));
      chk_strobe = $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0) begin
        iss_en = NO'($urandom); iss_idx = (NO*IW)'($urandom); iss_wide = NO'($urandom);
      end
      if ($urandom_range(0, 2) == 0) begin
        exe_en = NO'($urandom); exe_idx = (NO*IW)'($urandom); exe_wide = NO'($urandom);
        exe_mem = ($urandom_range(0, 3) == 0);
      end
      if ($urandom_range(0, 3) == 0) begin
        ret_en = NO'($urandom); ret_idx = (NO*IW)'($urandom); ret_wide = $urandom_range(0, 1);
        ret_delay = DW'($urandom_range(0, 10));
      end
      need = $countones(ret_en) + (exe_mem ? 0 : $countones(exe_en));
      if (need > NS - pend_cnt()) begin exe_en = '0; ret_en = '0; end
      cyc();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule